// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block walks a ring of transmit descriptors held in a small local memory. Each entry carries a 16-bit control/status word, a 16-bit frame length and a 32-bit buffer address. Software fills entries through a write port and reads them back through a read port. It sets the ring start index and then issues a clear-halt command.

From then on the sequencer polls the entry at its current index. If the entry is owned by the hardware, it presents a transmit request carrying the address, the length and three per-frame flags to a downstream MAC. It waits for the MAC to report completion and writes the completion status back into the entry's control word, which also returns ownership to software. It then moves to the next index, or back to the ring start when the entry asks for a wrap.

The sequencer parks in a halted state when it meets an entry software has not handed over, and stays there until the next clear-halt. A level-sensitive graceful-stop control lets the frame in flight finish and then holds the engine idle. Three sticky, write-one-to-clear event bits report frame completion, the graceful-stop point and halt entry.

Top module: `tx_bd_ring`

## Requirements
- R1: After reset, `halted` is 1, `tx_valid` is 0, `evt` is 0, every descriptor reads back as zero, and both the ring start and the current index are 0.
- R2: After `clr_halt`, if the current descriptor has its ownership bit (control bit 15) set, the block raises `tx_valid` with `tx_ptr`, `tx_len` and `tx_flags` taken from that descriptor. `tx_flags` is {control bit 12 interrupt, bit 11 last, bit 10 append-CRC}. All of these stay stable until `tx_ready` is seen high at a clock edge.
- R3: On the clock edge where `tx_done` is high, the descriptor's control word is written back with bit 15 cleared and bits 3:0 replaced by `tx_stat`. All other control bits and the length and address fields are unchanged.
- R4: After a completion, the next descriptor polled is the ring start if the finished descriptor had its wrap bit (control bit 13) set. Otherwise it is the current index plus one, with the index after DEPTH-1 being 0.
- R5: When the polled descriptor has bit 15 clear, the block enters the halted state, sets `halted` and sets `evt[2]`. It stays halted, fetching nothing, until `clr_halt`.
- R6: A ring-start write while halted also moves the next poll to that index. At any other time it changes only the target of later wraps.
- R7: While `grace_stop` is high, a frame already requested runs to completion. At the next poll no descriptor is fetched, `evt[1]` is set and `tx_valid` stays low. Lowering `grace_stop` resumes polling at the next index.
- R8: Completing a descriptor whose control bit 12 is set raises `evt[0]`. A completion without that bit leaves `evt[0]` unchanged.
- R9: Event bits are sticky. Writing 1 to an `evt_clr` bit clears it, and a new event in the same cycle as its clear leaves the bit set.
- R10: At most one frame is outstanding: `tx_valid` stays low from the accepting edge until the completion has been written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bd_we | input | 1 | Software descriptor write strobe |
| bd_widx | input | 3 | Descriptor index written |
| bd_wctl | input | 16 | Control/status word written |
| bd_wlen | input | 16 | Length written |
| bd_wptr | input | 32 | Buffer address written |
| bd_ridx | input | 3 | Descriptor index read back |
| bd_rctl | output | 16 | Control/status word read back |
| bd_rlen | output | 16 | Length read back |
| bd_rptr | output | 32 | Buffer address read back |
| ring_base_we | input | 1 | Ring start write strobe |
| ring_base | input | 3 | Ring start index |
| clr_halt | input | 1 | Clear-halt command pulse |
| grace_stop | input | 1 | Graceful-stop control level |
| evt_clr | input | 3 | Write-one-to-clear for the event bits |
| evt | output | 3 | Events: [0] frame interrupt, [1] graceful stop reached, [2] halted |
| halted | output | 1 | Engine is in the halted state |
| tx_valid | output | 1 | Transmit request to the MAC |
| tx_ready | input | 1 | MAC accepts the request |
| tx_ptr | output | 32 | Buffer address of the request |
| tx_len | output | 16 | Frame length of the request |
| tx_flags | output | 3 | {interrupt, last, append-CRC} |
| tx_done | input | 1 | MAC completion pulse |
| tx_stat | input | 4 | Completion error/statistics bits |

## Verification
A `clr_halt` pulse moves the engine to polling on the next edge, and a ready descriptor then drives `tx_valid` one edge after that. A completion is written back, and its event bit set, on the very edge that samples `tx_done`. Halt entry and the graceful-stop event follow exactly one edge after that write-back. The bench drives inputs on falling edges and reads each result on the first falling edge after the edge it is due at. It waits for a request by polling and does not count cycles. It holds `tx_ready` low for a random number of cycles to confirm the request stays stable, and checks that `tx_valid` stays low through every cycle of a completion wait and a graceful stop.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
    localparam int CTL_W    = 16;
    localparam int LEN_W    = 16;
    localparam int PTR_W    = 32;
    localparam int STAT_W   = 4;
    localparam int EVT_N    = 3;

    localparam int B_OWN    = 15;
    localparam int B_WRAP   = 13;
    localparam int B_IRQ    = 12;
    localparam int B_LAST   = 11;
    localparam int B_CRC    = 10;

    localparam int E_FRAME  = 0;
    localparam int E_STOP   = 1;
    localparam int E_HALT   = 2;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } bd_t;

    typedef struct packed {
        logic irq;
        logic last;
        logic crc;
    } txflags_t;

    typedef enum logic [2:0] {
        S_HALT,
        S_POLL,
        S_REQ,
        S_WAIT,
        S_PAUSE
    } eng_st_t;

    function automatic logic [CTL_W-1:0] bd_retire(input logic [CTL_W-1:0] ctl,
                                                   input logic [STAT_W-1:0] st);
        logic [CTL_W-1:0] r;
        r = ctl;
        r[B_OWN] = 1'b0;
        r[STAT_W-1:0] = st;
        return r;
    endfunction

    function automatic txflags_t bd_flags(input logic [CTL_W-1:0] ctl);
        txflags_t f;
        f.irq  = ctl[B_IRQ];
        f.last = ctl[B_LAST];
        f.crc  = ctl[B_CRC];
        return f;
    endfunction
endpackage

// File: rtl/txbd_mem.sv
module txbd_mem
    import txbd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [IW-1:0]    sw_idx,
    input  bd_t              sw_bd,
    input  logic             wb_en,
    input  logic [IW-1:0]    wb_idx,
    input  logic [CTL_W-1:0] wb_ctl,
    input  logic [IW-1:0]    eng_idx,
    output bd_t              eng_bd,
    input  logic [IW-1:0]    sw_ridx,
    output bd_t              sw_rbd
);
    bd_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (sw_we) mem[sw_idx] <= sw_bd;
            // engine write-back owns the control word on a collision
            if (wb_en) mem[wb_idx].ctl <= wb_ctl;
        end
    end

    assign eng_bd = mem[eng_idx];
    assign sw_rbd = mem[sw_ridx];

    AST_RETIRE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> !mem[$past(wb_idx)].ctl[B_OWN])
        else $error("retired descriptor still owned"); // R3
endmodule

// File: rtl/txbd_seq.sv
module txbd_seq
    import txbd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_halt,
    input  logic              grace_stop,
    input  logic              base_we,
    input  logic [IW-1:0]     base_idx,
    input  bd_t               cur_bd,
    output logic [IW-1:0]     cur_idx,
    input  logic              tx_ready,
    input  logic              tx_done,
    input  logic [STAT_W-1:0] tx_stat,
    output logic              tx_valid,
    output logic [PTR_W-1:0]  tx_ptr,
    output logic [LEN_W-1:0]  tx_len,
    output txflags_t          tx_flags,
    output logic              wb_en,
    output logic [IW-1:0]     wb_idx,
    output logic [CTL_W-1:0]  wb_ctl,
    output logic              halted,
    output logic [EVT_N-1:0]  ev_set
);
    eng_st_t       st;
    bd_t           held;
    logic [IW-1:0] base_q;
    logic [IW-1:0] step_idx;

    assign step_idx = (cur_idx == IW'(DEPTH - 1)) ? '0 : cur_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_HALT;
            cur_idx <= '0;
            base_q  <= '0;
            held    <= '0;
        end else begin
            if (base_we) begin
                base_q <= base_idx;
                if (st == S_HALT) cur_idx <= base_idx;
            end
            unique case (st)
                S_HALT:  if (clr_halt) st <= S_POLL;
                S_POLL: begin
                    if (grace_stop)          st <= S_PAUSE;
                    else if (cur_bd.ctl[B_OWN]) begin
                        held <= cur_bd;
                        st   <= S_REQ;
                    end else                 st <= S_HALT;
                end
                S_REQ:   if (tx_ready) st <= S_WAIT;
                S_WAIT: begin
                    if (tx_done) begin
                        st      <= S_POLL;
                        cur_idx <= held.ctl[B_WRAP] ? base_q : step_idx;
                    end
                end
                S_PAUSE: if (!grace_stop) st <= S_POLL;
                default: st <= S_HALT;
            endcase
        end
    end

    assign tx_valid = (st == S_REQ);
    assign tx_ptr   = held.ptr;
    assign tx_len   = held.len;
    assign tx_flags = bd_flags(held.ctl);
    assign halted   = (st == S_HALT);

    assign wb_en  = (st == S_WAIT) && tx_done;
    assign wb_idx = cur_idx;
    assign wb_ctl = bd_retire(held.ctl, tx_stat);

    always_comb begin
        ev_set         = '0;
        ev_set[E_FRAME] = wb_en && held.ctl[B_IRQ];
        ev_set[E_STOP]  = (st == S_POLL) && grace_stop;
        ev_set[E_HALT]  = (st == S_POLL) && !grace_stop && !cur_bd.ctl[B_OWN];
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_ptr) && $stable(tx_len) && $stable(tx_flags))
        else $error("request changed before acceptance"); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready |=> !tx_valid)
        else $error("second request while one outstanding"); // R10
    AST_HALT_PARKS: assert property (@(posedge clk) disable iff (rst)
        halted && !clr_halt |=> halted && !tx_valid)
        else $error("left halted state without clear-halt"); // R5
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ev_set[E_STOP] |=> !tx_valid)
        else $error("fetch during graceful stop"); // R7
endmodule

// File: rtl/txbd_evt.sv
module txbd_evt #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] evt
);
    always_ff @(posedge clk) begin
        if (rst) evt <= '0;
        else     evt <= (evt & ~clr) | set;
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> evt[g])
            else $error("event lost"); // R9
        AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
            evt[g] && !clr[g] |=> evt[g])
            else $error("event dropped without clear"); // R9
        AST_EVT_W1C: assert property (@(posedge clk) disable iff (rst)
            clr[g] && !set[g] |=> !evt[g])
            else $error("event not cleared"); // R9
    end
endmodule

// File: rtl/tx_bd_ring.sv
module tx_bd_ring
    import txbd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bd_we,
    input  logic [IW-1:0]     bd_widx,
    input  logic [CTL_W-1:0]  bd_wctl,
    input  logic [LEN_W-1:0]  bd_wlen,
    input  logic [PTR_W-1:0]  bd_wptr,
    input  logic [IW-1:0]     bd_ridx,
    output logic [CTL_W-1:0]  bd_rctl,
    output logic [LEN_W-1:0]  bd_rlen,
    output logic [PTR_W-1:0]  bd_rptr,
    input  logic              ring_base_we,
    input  logic [IW-1:0]     ring_base,
    input  logic              clr_halt,
    input  logic              grace_stop,
    input  logic [EVT_N-1:0]  evt_clr,
    output logic [EVT_N-1:0]  evt,
    output logic              halted,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [PTR_W-1:0]  tx_ptr,
    output logic [LEN_W-1:0]  tx_len,
    output logic [2:0]        tx_flags,
    input  logic              tx_done,
    input  logic [STAT_W-1:0] tx_stat
);
    bd_t              sw_bd, eng_bd, rd_bd;
    logic [IW-1:0]    cur_idx, wb_idx;
    logic             wb_en;
    logic [CTL_W-1:0] wb_ctl;
    logic [EVT_N-1:0] ev_set;
    txflags_t         flags_s;

    assign sw_bd = '{ctl: bd_wctl, len: bd_wlen, ptr: bd_wptr};

    txbd_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .sw_we(bd_we), .sw_idx(bd_widx), .sw_bd(sw_bd),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_ctl(wb_ctl),
        .eng_idx(cur_idx), .eng_bd(eng_bd),
        .sw_ridx(bd_ridx), .sw_rbd(rd_bd)
    );

    txbd_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst),
        .clr_halt(clr_halt), .grace_stop(grace_stop),
        .base_we(ring_base_we), .base_idx(ring_base),
        .cur_bd(eng_bd), .cur_idx(cur_idx),
        .tx_ready(tx_ready), .tx_done(tx_done), .tx_stat(tx_stat),
        .tx_valid(tx_valid), .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_flags(flags_s),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_ctl(wb_ctl),
        .halted(halted), .ev_set(ev_set)
    );

    txbd_evt #(.N(EVT_N)) u_evt (
        .clk(clk), .rst(rst), .set(ev_set), .clr(evt_clr), .evt(evt)
    );

    assign tx_flags = flags_s;
    assign bd_rctl  = rd_bd.ctl;
    assign bd_rlen  = rd_bd.len;
    assign bd_rptr  = rd_bd.ptr;

    AST_HALT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> evt[E_HALT])
        else $error("halt entered without event"); // R5
endmodule

// File: tb/tx_bd_ring_bench.sv
module tx_bd_ring_bench;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bd_we = 1'b0;
    logic [2:0]  bd_widx = '0;
    logic [15:0] bd_wctl = '0;
    logic [15:0] bd_wlen = '0;
    logic [31:0] bd_wptr = '0;
    logic [2:0]  bd_ridx = '0;
    logic [15:0] bd_rctl;
    logic [15:0] bd_rlen;
    logic [31:0] bd_rptr;
    logic        ring_base_we = 1'b0;
    logic [2:0]  ring_base = '0;
    logic        clr_halt = 1'b0;
    logic        grace_stop = 1'b0;
    logic [2:0]  evt_clr = '0;
    logic [2:0]  evt;
    logic        halted;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_ptr;
    logic [15:0] tx_len;
    logic [2:0]  tx_flags;
    logic        tx_done = 1'b0;
    logic [3:0]  tx_stat = '0;

    tx_bd_ring u_tx_bd_ring (
        .clk(clk), .rst(rst),
        .bd_we(bd_we), .bd_widx(bd_widx), .bd_wctl(bd_wctl), .bd_wlen(bd_wlen), .bd_wptr(bd_wptr),
        .bd_ridx(bd_ridx), .bd_rctl(bd_rctl), .bd_rlen(bd_rlen), .bd_rptr(bd_rptr),
        .ring_base_we(ring_base_we), .ring_base(ring_base),
        .clr_halt(clr_halt), .grace_stop(grace_stop),
        .evt_clr(evt_clr), .evt(evt), .halted(halted),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ptr(tx_ptr), .tx_len(tx_len),
        .tx_flags(tx_flags), .tx_done(tx_done), .tx_stat(tx_stat)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_ctl [D];
    logic [15:0] m_len [D];
    logic [31:0] m_ptr [D];
    int exp_idx = 0;
    int exp_base = 0;
    bit intr_acc = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] retire_exp(input logic [15:0] c, input logic [3:0] s);
        return {1'b0, c[14:4], s};
    endfunction

    function automatic int next_exp(input int idx, input logic [15:0] c);
        return c[13] ? exp_base : (idx + 1) % D;
    endfunction

    task automatic wr_bd(input int idx, input logic [15:0] c, input logic [15:0] l, input logic [31:0] p);
        @(negedge clk);
        bd_we = 1'b1; bd_widx = idx[2:0]; bd_wctl = c; bd_wlen = l; bd_wptr = p;
        @(negedge clk);
        bd_we = 1'b0;
        m_ctl[idx] = c; m_len[idx] = l; m_ptr[idx] = p;
    endtask

    task automatic kick();
        @(negedge clk); clr_halt = 1'b1;
        @(negedge clk); clr_halt = 1'b0;
    endtask

    task automatic clear_evts();
        @(negedge clk); evt_clr = 3'b111;
        @(negedge clk); evt_clr = 3'b000;
        chk("R9", "events after clear", 64'(evt), 64'h0);
    endtask

    task automatic accept_frame(input int idx, input string req);
        int t = 0;
        while (!tx_valid && t < 100) begin @(negedge clk); t++; end
        chk(req, "request raised", 64'(tx_valid), 64'h1);
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk("R2", "request held while not ready", {31'h0, tx_valid, tx_ptr}, {32'h1, m_ptr[idx]});
        end
        chk(req, "request address", 64'(tx_ptr), 64'(m_ptr[idx]));
        chk(req, "request length", 64'(tx_len), 64'(m_len[idx]));
        chk("R2", "request flags", 64'(tx_flags), 64'({m_ctl[idx][12], m_ctl[idx][11], m_ctl[idx][10]}));
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R10", "no request after accept", 64'(tx_valid), 64'h0);
    endtask

    task automatic finish_frame(input int idx, input logic [3:0] s);
        logic [15:0] c;
        c = m_ctl[idx];
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk("R10", "no request while outstanding", 64'(tx_valid), 64'h0);
        end
        tx_done = 1'b1; tx_stat = s;
        @(negedge clk);
        tx_done = 1'b0;
        bd_ridx = idx[2:0];
        #1;
        chk("R3", "retired control word", 64'(bd_rctl), 64'(retire_exp(c, s)));
        chk("R3", "retired len/ptr kept", {bd_rlen, bd_rptr}, {m_len[idx], m_ptr[idx]});
        m_ctl[idx] = retire_exp(c, s);
        intr_acc = intr_acc | c[12];
        chk("R8", "frame event", 64'(evt[0]), 64'(intr_acc));
        exp_idx = next_exp(idx, c);
    endtask

    task automatic expect_halt_after_frame();
        chk("R4", "polling after completion", 64'(halted), 64'h0);
        @(negedge clk);
        chk("R5", "halted on unowned descriptor", 64'(halted), 64'h1);
        chk("R5", "halt event", 64'(evt[2]), 64'h1);
    endtask

    task automatic random_round();
        int order[$];
        bit vis [D];
        int idx;
        int n;
        logic [15:0] c;
        for (int i = 0; i < D; i++) vis[i] = 1'b0;
        clear_evts();
        intr_acc = 0;
        idx = exp_idx;
        n = 1 + ($urandom % 4);
        for (int k = 0; k < n; k++) begin
            if (vis[idx]) break;
            vis[idx] = 1'b1;
            c = 16'(($urandom & 32'h5FFF) | 32'h8000);
            if ($urandom % 4 == 0) c[13] = 1'b1;
            wr_bd(idx, c, 16'($urandom), $urandom);
            order.push_back(idx);
            idx = next_exp(idx, c);
        end
        chk("R5", "halted before clear-halt", 64'(halted), 64'h1);
        kick();
        foreach (order[k]) begin
            accept_frame(order[k], "R4");
            finish_frame(order[k], 4'($urandom));
        end
        expect_halt_after_frame();
    endtask

    initial begin
        int i0;
        int nb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "halted after reset", 64'(halted), 64'h1);
        chk("R1", "no request after reset", 64'(tx_valid), 64'h0);
        chk("R1", "events after reset", 64'(evt), 64'h0);
        bd_ridx = 3'd3; #1;
        chk("R1", "descriptor cleared", {bd_rctl, bd_rlen, bd_rptr}, 64'h0);
        for (int i = 0; i < D; i++) begin m_ctl[i] = '0; m_len[i] = '0; m_ptr[i] = '0; end

        // R5 empty ring: clear-halt returns to halt
        kick();
        chk("R5", "polling after clear-halt", 64'(halted), 64'h0);
        @(negedge clk);
        chk("R5", "halted on empty ring", 64'(halted), 64'h1);
        chk("R5", "halt event on empty ring", 64'(evt[2]), 64'h1);
        clear_evts();

        // R9 set wins over clear in the same cycle
        @(negedge clk); clr_halt = 1'b1;
        @(negedge clk); clr_halt = 1'b0; evt_clr = 3'b100;
        @(negedge clk); evt_clr = 3'b000;
        chk("R9", "set wins over clear", 64'(evt[2]), 64'h1);

        // R6 ring start moved while halted
        @(negedge clk); ring_base_we = 1'b1; ring_base = 3'd5;
        @(negedge clk); ring_base_we = 1'b0;
        exp_base = 5; exp_idx = 5;
        clear_evts();
        intr_acc = 0;
        wr_bd(5, 16'h8C00, 16'h0040, 32'hA5A50005);
        kick();
        accept_frame(5, "R6");
        finish_frame(5, 4'h3);
        expect_halt_after_frame();

        for (int r = 0; r < 25; r++) random_round();

        // R7 graceful stop with R6 base change while running
        clear_evts();
        intr_acc = 0;
        i0 = exp_idx;
        nb = (exp_base + 3) % D;
        if (nb == i0) nb = (nb + 1) % D;
        wr_bd(i0, 16'hAC00, 16'h0123, 32'h0BAD0001);
        wr_bd(nb, 16'h9C00, 16'h0456, 32'h0BAD0002);
        kick();
        accept_frame(i0, "R7");
        @(negedge clk); ring_base_we = 1'b1; ring_base = 3'(nb); grace_stop = 1'b1;
        @(negedge clk); ring_base_we = 1'b0;
        exp_base = nb;
        finish_frame(i0, 4'h5);
        chk("R6", "wrap goes to rewritten start", 64'(exp_idx), 64'(nb));
        @(negedge clk);
        chk("R7", "stop event", 64'(evt[1]), 64'h1);
        chk("R7", "not halted while stopped", 64'(halted), 64'h0);
        repeat (4) begin
            @(negedge clk);
            chk("R7", "no fetch while stopped", 64'(tx_valid), 64'h0);
        end
        grace_stop = 1'b0;
        accept_frame(nb, "R7");
        finish_frame(nb, 4'hA);
        expect_halt_after_frame();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule